// File: doc/BRIEF.md
# DDR3 Mode Register 2 Decoder with Write-Latency Strobe

This block snoops the command bus between a memory controller and a DDR3 device. It recognises mode register set commands that target mode register 2 and keeps a copy of what they program: the partial-array retention code, the CAS write latency, the auto self-refresh and extended-temperature flags, and the dynamic write termination setting. Address bits that must be zero, and the reserved termination code, raise sticky error flags. Only reset clears these flags.

An additive latency is supplied on an input. Each write command seen on the bus starts its own countdown. The count is the additive latency plus the CAS write latency in force when the write is sampled, and when it ends a one-cycle data-valid strobe is raised. Writes may be issued on consecutive cycles.

The stored partial-array code is turned into an 8-bit mask of the banks whose contents survive self-refresh. Bit b of the mask stands for bank b. The mask appears only while the self-refresh-active input is high.

Top module: `mr2_wl_tracker`

## Requirements
- R1: A mode register 2 write is taken only at a rising edge where cs_n, ras_n, cas_n and we_n are all 0 and ba = 3'b010. Any other bank address, and any other command, leaves every stored field unchanged.
- R2: While sr_active = 1, bank_keep is decoded from addr[2:0] of the last mode register 2 write, with bit b meaning bank b is kept: 0→8'hFF, 1→8'h0F, 2→8'h03, 3→8'h01, 4→8'hFC, 5→8'hF0, 6→8'hC0, 7→8'h80.
- R3: While sr_active = 0, bank_keep reads 8'hFF.
- R4: addr[5:3] = c sets cwl_clk to 5 + c. Code 0 gives 5 and code 7 gives 12.
- R5: asr_en follows the stored addr[6], and srt_ext follows the stored addr[7].
- R6: addr[10:9] sets the stored termination code, which is reported on odt_sel: 2'b00 off, 2'b01 RZQ/4, 2'b10 RZQ/2.
- R7: A write with addr[10:9] = 2'b11 sets rsvd_err (sticky) and keeps the previous termination code. The other fields of that write are still stored.
- R8: A write with any of addr[5], addr[8], addr[11], addr[12] or addr[13] set raises mbz_err, which stays set until reset. The fields are still stored.
- R9: While wr_lvl = 1, odt_sel reads 2'b00 whatever code is stored. The stored code returns when wr_lvl falls.
- R10: A write command (cs_n=0, ras_n=1, cas_n=0, we_n=0) sampled at edge n gives wdata_valid = 1 for exactly the one cycle sampled at edge n + WL. Here WL = add_lat + cwl_clk, both taken at edge n. The range is from 5 up to 27 with the default 4-bit add_lat.
- R11: Write commands on consecutive or nearby cycles each produce their own strobe, so the strobes land in consecutive or nearby cycles.
- R12: After reset, bank_keep = 8'hFF (with sr_active = 1), cwl_clk = 5, asr_en = srt_ext = 0, odt_sel = 0, both error flags are 0, and wdata_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 14 | Address bus |
| add_lat | input | 4 | Additive latency in clocks |
| wr_lvl | input | 1 | Write leveling in progress |
| sr_active | input | 1 | Self-refresh active |
| cwl_clk | output | 4 | CAS write latency in clocks |
| asr_en | output | 1 | Auto self-refresh enabled |
| srt_ext | output | 1 | Extended temperature self-refresh selected |
| odt_sel | output | 2 | Effective dynamic write termination code |
| bank_keep | output | 8 | Banks retained during self-refresh |
| mbz_err | output | 1 | Sticky: a must-be-zero bit was set |
| rsvd_err | output | 1 | Sticky: the reserved termination code was written |
| wdata_valid | output | 1 | Write data window strobe |

## Verification
A corrupted field register shows up on cwl_clk, odt_sel or bank_keep on the first negedge after the command that wrote it. It also moves every later write strobe by the size of the error. A slot lost or misplaced in the latency pipeline only shows at the moment a strobe is due, which is up to 27 cycles after the write. For this reason the bench watches every cycle of each window rather than only the expected one. Back-to-back writes expose a pipeline that merges or drops neighbouring entries.

// File: rtl/mr2_pkg.sv
package mr2_pkg;

    localparam int CWL_BASE   = 5;
    localparam int CWL_MAX    = 12;
    localparam int CWL_W      = 4;
    localparam int PASR_W     = 3;
    localparam int MR_TARGET  = 2;

    typedef enum logic [1:0] {
        TERM_OFF  = 2'b00,
        TERM_RZQ4 = 2'b01,
        TERM_RZQ2 = 2'b10,
        TERM_RSVD = 2'b11
    } term_e;

    typedef struct packed {
        logic [PASR_W-1:0] pasr;
        logic [2:0]        cwl_code;
        logic              asr;
        logic              srt;
        term_e             term;
        logic              mbz_err;
        logic              rsvd_err;
    } mr2_fields_t;

endpackage

// File: rtl/mr2_cmd_decode.sv
module mr2_cmd_decode #(
    parameter int BA_W   = 3,
    parameter int MR_SEL = mr2_pkg::MR_TARGET
) (
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    output logic            mrs_hit,
    output logic            wr_hit
);
    logic sel;

    always_comb begin
        sel     = ~cs_n;
        mrs_hit = sel & ~ras_n & ~cas_n & ~we_n & (ba == BA_W'(MR_SEL));
        wr_hit  = sel &  ras_n & ~cas_n & ~we_n;
    end

endmodule

// File: rtl/mr2_field_reg.sv
module mr2_field_reg
    import mr2_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_hit,
    input  logic [ADDR_W-1:0] addr,
    output mr2_fields_t       fields
);
    mr2_fields_t st_d, st_q;
    logic        mbz_bits;

    always_comb begin
        mbz_bits = addr[5] | addr[8] | (|addr[ADDR_W-1:11]);
        st_d     = st_q;
        if (mrs_hit) begin
            st_d.pasr     = addr[2:0];
            st_d.cwl_code = addr[5:3];
            st_d.asr      = addr[6];
            st_d.srt      = addr[7];
            if (addr[10:9] == 2'b11) begin
                st_d.rsvd_err = 1'b1;
            end else begin
                st_d.term = term_e'(addr[10:9]);
            end
            if (mbz_bits) begin
                st_d.mbz_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields = st_q;

    // R1: without a mode register 2 write nothing stored changes
    a_r1_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs_hit |=> $stable(st_q));

    // R7: the reserved code leaves the termination setting alone
    a_r7_rsvd_keeps_term: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_hit && addr[10:9] == 2'b11) |=> $stable(st_q.term));

    // R7: the reserved-code flag is sticky
    a_r7_rsvd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsvd_err |=> st_q.rsvd_err);

    // R8: the must-be-zero flag is sticky
    a_r8_mbz_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mbz_err |=> st_q.mbz_err);

    // R6: a stored termination code is never the reserved one
    a_r6_term_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.term != TERM_RSVD);

endmodule

// File: rtl/mr2_bank_mask.sv
module mr2_bank_mask #(
    parameter int BANKS  = 8,
    parameter int CODE_W = mr2_pkg::PASR_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic              sr_active,
    output logic [BANKS-1:0]  keep
);
    localparam int HALF_CODES = 1 << (CODE_W - 1);

    function automatic logic bank_kept(input int c, input int b);
        if (c == 0)                return 1'b1;
        else if (c < HALF_CODES)   return b < (BANKS >> c);
        else if (c == HALF_CODES)  return b >= (BANKS / 4);
        else                       return b >= (BANKS - (BANKS >> (c - HALF_CODES)));
    endfunction

    logic [BANKS-1:0] keep_raw;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign keep_raw[b] = bank_kept(int'(code), b);
    end

    assign keep = sr_active ? keep_raw : '1;

endmodule

// File: rtl/mr2_wl_pipe.sv
module mr2_wl_pipe #(
    parameter int DEPTH = 27,
    parameter int WL_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [WL_W-1:0] wl,
    output logic            strobe
);
    typedef struct packed {
        logic [DEPTH-1:0] slot;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d.slot = {1'b0, p_q.slot[DEPTH-1:1]};
        for (int i = 0; i < DEPTH; i++) begin
            if (push && wl == WL_W'(i + 1)) begin
                p_d.slot[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign strobe = p_q.slot[0];

    // Checker: the number of writes still waiting for their strobe
    logic [WL_W:0] pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + (WL_W+1)'(push) - (WL_W+1)'(strobe);
        end
    end

    // R10: every strobe belongs to an earlier write
    a_r10_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> pend_q != '0);

    // R10: a pushed latency fits the pipeline
    a_r10_wl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (wl >= WL_W'(1) && wl <= WL_W'(DEPTH)));

endmodule

// File: rtl/mr2_wl_tracker.sv
module mr2_wl_tracker
    import mr2_pkg::*;
#(
    parameter int AL_W   = 4,
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int BANKS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AL_W-1:0]   add_lat,
    input  logic              wr_lvl,
    input  logic              sr_active,
    output logic [CWL_W-1:0]  cwl_clk,
    output logic              asr_en,
    output logic              srt_ext,
    output logic [1:0]        odt_sel,
    output logic [BANKS-1:0]  bank_keep,
    output logic              mbz_err,
    output logic              rsvd_err,
    output logic              wdata_valid
);
    localparam int AL_MAX = (1 << AL_W) - 1;
    localparam int DEPTH  = AL_MAX + CWL_MAX;
    localparam int WL_W   = $clog2(DEPTH + 1);

    logic            mrs_hit;
    logic            wr_hit;
    mr2_fields_t     fields;
    logic [WL_W-1:0] wl_total;

    mr2_cmd_decode #(.BA_W(BA_W), .MR_SEL(MR_TARGET)) i_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .mrs_hit (mrs_hit),
        .wr_hit  (wr_hit)
    );

    mr2_field_reg #(.ADDR_W(ADDR_W)) i_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .mrs_hit (mrs_hit),
        .addr    (addr),
        .fields  (fields)
    );

    mr2_bank_mask #(.BANKS(BANKS), .CODE_W(PASR_W)) i_mask (
        .code      (fields.pasr),
        .sr_active (sr_active),
        .keep      (bank_keep)
    );

    always_comb begin
        cwl_clk  = CWL_W'(CWL_BASE) + CWL_W'(fields.cwl_code);
        wl_total = WL_W'(add_lat) + WL_W'(cwl_clk);
        asr_en   = fields.asr;
        srt_ext  = fields.srt;
        odt_sel  = wr_lvl ? TERM_OFF : fields.term;
        mbz_err  = fields.mbz_err;
        rsvd_err = fields.rsvd_err;
    end

    mr2_wl_pipe #(.DEPTH(DEPTH), .WL_W(WL_W)) i_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (wr_hit),
        .wl     (wl_total),
        .strobe (wdata_valid)
    );

    // R9: termination is reported off during write leveling
    a_r9_lvl_term_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lvl |-> odt_sel == 2'b00);

    // R2: a retention mask is never empty
    a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> bank_keep != '0);

    // R3: outside self-refresh every bank reads as kept
    a_r3_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_active |-> &bank_keep);

    // R4: reported CAS write latency stays within 5..12
    a_r4_cwl_range: assert property (@(posedge clk) disable iff (!rst_n)
        cwl_clk >= CWL_W'(CWL_BASE) && cwl_clk <= CWL_W'(CWL_MAX));

endmodule

// File: tb/test_mr2_wl_tracker.sv
`timescale 1ns/1ps
module test_mr2_wl_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [3:0]  add_lat = '0;
    logic        wr_lvl = 1'b0, sr_active = 1'b1;
    logic [3:0]  cwl_clk;
    logic        asr_en, srt_ext, mbz_err, rsvd_err, wdata_valid;
    logic [1:0]  odt_sel;
    logic [7:0]  bank_keep;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mr2_wl_tracker i_mr2_wl_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .add_lat(add_lat), .wr_lvl(wr_lvl),
        .sr_active(sr_active), .cwl_clk(cwl_clk), .asr_en(asr_en),
        .srt_ext(srt_ext), .odt_sel(odt_sel), .bank_keep(bank_keep),
        .mbz_err(mbz_err), .rsvd_err(rsvd_err), .wdata_valid(wdata_valid)
    );

    // Vector table: address of a mode register 2 write and expected results
    localparam logic [13:0] T_ADDR [8] = '{14'h000, 14'h249, 14'h492, 14'h0DB,
                                          14'h204, 14'h44D, 14'h096, 14'h2DF};
    localparam logic [7:0]  T_MASK [8] = '{8'hFF, 8'h0F, 8'h03, 8'h01,
                                          8'hFC, 8'hF0, 8'hC0, 8'h80};
    localparam logic [3:0]  T_CWL  [8] = '{4'd5, 4'd6, 4'd7, 4'd8, 4'd5, 4'd6, 4'd7, 4'd8};
    localparam logic        T_ASR  [8] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic        T_SRT  [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [1:0]  T_ODT  [8] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1};

    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_NOP = 4'b0111;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [2:0] b, input logic [13:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
    endtask

    // One command sampled at the next edge; returns at the negedge after it
    task automatic issue(input logic [3:0] c, input logic [2:0] b, input logic [13:0] a);
        @(negedge clk);
        drive(c, b, a);
        @(negedge clk);
        drive(C_NOP, 3'b000, 14'h0);
    endtask

    // Called at the negedge after command edge n + j0; watches up to the later pulse + 1
    task automatic watch(input int j0, input int hi_a, input int hi_b, input string tag);
        int last = ((hi_a > hi_b) ? hi_a : hi_b) + 1;
        for (int j = j0; j <= last; j++) begin
            chk(tag, 32'(wdata_valid), 32'((j == hi_a) || (j == hi_b)));
            if (j < last) @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 mask", 32'(bank_keep), 32'hFF);
        chk("R12 cwl", 32'(cwl_clk), 32'd5);
        chk("R12 asr/srt", 32'({asr_en, srt_ext}), 32'd0);
        chk("R12 odt", 32'(odt_sel), 32'd0);
        chk("R12 errors", 32'({mbz_err, rsvd_err}), 32'd0);
        chk("R12 strobe", 32'(wdata_valid), 32'd0);

        // Table walk: R2 R4 R5 R6 then R10 with add_lat = i
        for (int i = 0; i < 8; i++) begin
            issue(C_MRS, 3'b010, T_ADDR[i]);
            chk("R2 mask", 32'(bank_keep), 32'(T_MASK[i]));
            chk("R4 cwl", 32'(cwl_clk), 32'(T_CWL[i]));
            chk("R5 asr", 32'(asr_en), 32'(T_ASR[i]));
            chk("R5 srt", 32'(srt_ext), 32'(T_SRT[i]));
            chk("R6 odt", 32'(odt_sel), 32'(T_ODT[i]));
            chk("R8 no mbz", 32'({mbz_err, rsvd_err}), 32'd0);
            add_lat = 4'(i);
            issue(C_WR, 3'b000, 14'h0);
            watch(0, int'(T_CWL[i]) + i - 1, -10, "R10 strobe");
        end

        // R1: other bank address and non-MRS command leave fields alone
        issue(C_MRS, 3'b001, 14'h0000);
        chk("R1 other mr mask", 32'(bank_keep), 32'h80);
        chk("R1 other mr cwl", 32'(cwl_clk), 32'd8);
        issue(4'b0001, 3'b010, 14'h0000);
        chk("R1 not mrs mask", 32'(bank_keep), 32'h80);
        chk("R1 not mrs odt", 32'(odt_sel), 32'd1);
        issue(4'b1000, 3'b010, 14'h0000);
        chk("R1 deselected cwl", 32'(cwl_clk), 32'd8);

        // R3: mask only while self-refresh is active
        sr_active = 1'b0;
        #1 chk("R3 mask idle", 32'(bank_keep), 32'hFF);
        sr_active = 1'b1;
        #1 chk("R3 mask back", 32'(bank_keep), 32'h80);

        // R9: write leveling hides termination
        wr_lvl = 1'b1;
        #1 chk("R9 lvl odt", 32'(odt_sel), 32'd0);
        wr_lvl = 1'b0;
        #1 chk("R9 after lvl", 32'(odt_sel), 32'd1);

        // R7: reserved code, pasr 5, cwl code 0
        issue(C_MRS, 3'b010, 14'h0605);
        chk("R7 rsvd flag", 32'(rsvd_err), 32'd1);
        chk("R7 odt kept", 32'(odt_sel), 32'd1);
        chk("R7 mask updated", 32'(bank_keep), 32'hF0);
        chk("R7 mbz clear", 32'(mbz_err), 32'd0);
        issue(C_MRS, 3'b010, 14'h0400);
        chk("R7 rsvd sticky", 32'(rsvd_err), 32'd1);
        chk("R6 odt rzq2", 32'(odt_sel), 32'd2);

        // R8 and R4: cwl code 7 sets A5 -> 12 clocks, flagged
        issue(C_MRS, 3'b010, 14'h0038);
        chk("R4 cwl max", 32'(cwl_clk), 32'd12);
        chk("R8 mbz A5", 32'(mbz_err), 32'd1);
        add_lat = 4'd15;
        issue(C_WR, 3'b000, 14'h0);
        watch(0, 26, -10, "R10 max latency");
        issue(C_MRS, 3'b010, 14'h0000);
        chk("R8 mbz sticky", 32'(mbz_err), 32'd1);
        chk("R4 cwl min", 32'(cwl_clk), 32'd5);

        // R11: back-to-back writes, WL = 5
        add_lat = 4'd0;
        @(negedge clk);
        drive(C_WR, 3'b000, 14'h0);
        @(negedge clk);
        @(negedge clk);
        drive(C_NOP, 3'b000, 14'h0);
        watch(1, 4, 5, "R11 back to back");

        // R11: writes two cycles apart with AL = 2, WL = 7
        add_lat = 4'd2;
        @(negedge clk);
        drive(C_WR, 3'b000, 14'h0);
        @(negedge clk);
        drive(C_NOP, 3'b000, 14'h0);
        @(negedge clk);
        drive(C_WR, 3'b000, 14'h0);
        @(negedge clk);
        drive(C_NOP, 3'b000, 14'h0);
        watch(2, 6, 8, "R11 spaced");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule